// File: doc/BRIEF.md
# Bus Error Status and Machine-Check Router

This block collects error events from the PCI side of a host bridge and turns them into processor notifications. It keeps three sticky flags:

- **System error.** The external active-low system-error pin was asserted.
- **Master abort.** The local master ended its own transaction with master abort.
- **Target abort.** The local master's transaction was ended by target abort.

Software clears a flag by writing a 1 to its bit.

Each flag has a separate machine-check enable and interrupt enable. A machine-check goes to one of two processors, and the routing depends on the error source:

- A system error goes to the processor named by a default-processor field.
- Both abort errors go to the processor named by a master-ID field.

A 32-bit error address register latches the transaction address of the first error that arrives while no flag is pending. It keeps that value until every flag has been cleared. A single-cycle register port gives access to status, enables, routing and the captured address. A two-state machine controls address capture:

- **ST_OPEN**: no flag is pending and the address register may load.
- **ST_HELD**: at least one flag is pending and the address is frozen.

The transitions are:

- **OPEN_TO_HELD**: any set event in ST_OPEN.
- **HELD_TO_OPEN**: the flag vector becomes all zero.
- **STAY_OPEN** and **STAY_HELD** otherwise.

Top module: `buserr_unit`

## Requirements
- R1: After reset the status, enable, route and error address registers all read zero, `mchk` is 0 and `irq` is 0.
- R2: A low level on `serr_n` passes through a two-flop synchronizer and sets status bit 0 on the third rising clock edge after it is first sampled low.
- R3: A one-cycle pulse on `ma_evt` sets status bit 1 and a pulse on `ta_evt` sets status bit 2, each at the next rising edge.
- R4: A write to the status register (offset 0) clears each flag whose bit in `wdata[2:0]` is 1. A flag whose bit is 0 is left unchanged.
- R5: When a set event and a write-1 clear hit the same flag in the same cycle, the flag ends up set.
- R6: The system-error flag, when its machine-check enable (enable register offset 1, bit 0) is set, drives `mchk[d]`, where d is route register (offset 2) bit 0.
- R7: The master-abort and target-abort flags, with their machine-check enables (enable bits 1 and 2) set, drive `mchk[m]`, where m is route register bit 1.
- R8: `irq` is high while any flag is set whose interrupt enable is set. The interrupt enables are enable bits 3, 4 and 5 for flags 0, 1 and 2.
- R9: The error address register (offset 3) loads `txn_addr` on a set event that occurs while all flags are clear. It then holds its value while any flag is set, and it ignores writes.
- R10: Enable bits [5:0] and route bits [1:0] are written from `wdata` and read back unchanged in the low bits of `rdata`, with the upper bits reading zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| serr_n | input | 1 | Asynchronous active-low system-error pin |
| ma_evt | input | 1 | Local master signalled master abort (pulse) |
| ta_evt | input | 1 | Local master received target abort (pulse) |
| txn_addr | input | 32 | Address of the current transaction |
| reg_addr | input | 2 | Register select: 0 status, 1 enable, 2 route, 3 error address |
| wr_en | input | 1 | Write strobe for the selected register |
| wdata | input | 6 | Write data |
| rdata | output | 32 | Read data of the selected register (combinational) |
| mchk | output | 2 | Level machine-check request, one bit per processor |
| irq | output | 1 | Level interrupt request toward the interrupt controller |

## Verification
The embedded assertions check three things on every cycle:

- A flag never drops without a write-1 clear.
- A set event always wins over a same-cycle clear.
- The address is frozen while the state machine is in ST_HELD, and ST_OPEN implies no pending flag.

They also check that no request is raised with all flags clear.

Some behaviours only the bench scenarios show. These are the synchronizer latency of the system-error pin, the per-source steering of machine-checks when the route fields change, the interrupt enables, and the re-arming of address capture after all flags are cleared.

// File: rtl/buserr_pkg.sv
package buserr_pkg;
    localparam int ADDR_W  = 32;
    localparam int WD_W    = 6;
    localparam int RA_W    = 2;
    localparam int N_FLAG  = 3;
    localparam int N_CPU   = 2;
    localparam int CPU_W   = $clog2(N_CPU);
    localparam int ROUTE_W = 2 * CPU_W;
    localparam int EN_W    = 2 * N_FLAG;

    localparam int FLG_SYS = 0;
    localparam int FLG_MA  = 1;
    localparam int FLG_TA  = 2;

    typedef enum logic [RA_W-1:0] {
        REG_STATUS = 2'd0,
        REG_ENABLE = 2'd1,
        REG_ROUTE  = 2'd2,
        REG_EADDR  = 2'd3
    } reg_sel_t;

    typedef enum logic {
        ST_OPEN = 1'b0,
        ST_HELD = 1'b1
    } cap_state_t;
endpackage

// File: rtl/buserr_sync.sv
module buserr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    output logic active
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], pin_n};
    end

    assign active = ~chain_q[STAGES-1];
endmodule

// File: rtl/buserr_cfg.sv
module buserr_cfg
    import buserr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_enable,
    input  logic               wr_route,
    input  logic [WD_W-1:0]    wdata,
    output logic [EN_W-1:0]    en_q,
    output logic [ROUTE_W-1:0] route_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            route_q <= '0;
        end else begin
            if (wr_enable) en_q    <= wdata[EN_W-1:0];
            if (wr_route)  route_q <= wdata[ROUTE_W-1:0];
        end
    end
endmodule

// File: rtl/buserr_flags.sv
module buserr_flags
    import buserr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_FLAG-1:0] set_ev,
    input  logic [N_FLAG-1:0] clr,
    input  logic [ADDR_W-1:0] txn_addr,
    output logic [N_FLAG-1:0] flag_q,
    output logic [ADDR_W-1:0] err_addr_q
);
    cap_state_t        state_q, state_d;
    logic [N_FLAG-1:0] flag_d;
    logic              load_addr;

    // set has priority over a same-cycle write-1 clear
    always_comb flag_d = (flag_q & ~clr) | set_ev;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // next state and capture strobe
    always_comb begin
        state_d   = state_q;
        load_addr = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                if (|set_ev) begin
                    load_addr = 1'b1;
                    state_d   = ST_HELD;
                end
            end
            ST_HELD: begin
                if (flag_d == '0) state_d = ST_OPEN;
            end
            default: state_d = ST_OPEN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q     <= '0;
            err_addr_q <= '0;
        end else begin
            flag_q <= flag_d;
            if (load_addr) err_addr_q <= txn_addr;
        end
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flag_q & $past(flag_q & ~clr)) == $past(flag_q & ~clr))); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_ev) |=> ((flag_q & $past(set_ev)) == $past(set_ev))); // R5
    AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD) |=> $stable(err_addr_q)); // R9
    AST_OPEN_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN) |-> (flag_q == '0)); // R9
endmodule

// File: rtl/buserr_route.sv
module buserr_route
    import buserr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_FLAG-1:0]  flags,
    input  logic [EN_W-1:0]    en,
    input  logic [ROUTE_W-1:0] route,
    output logic [N_CPU-1:0]   mchk,
    output logic               irq
);
    logic [N_FLAG-1:0] mc_act;
    logic [N_FLAG-1:0] irq_act;
    logic [CPU_W-1:0]  dflt_cpu;
    logic [CPU_W-1:0]  mid_cpu;
    logic              abort_mc;

    assign mc_act   = flags & en[N_FLAG-1:0];
    assign irq_act  = flags & en[EN_W-1:N_FLAG];
    assign dflt_cpu = route[CPU_W-1:0];
    assign mid_cpu  = route[ROUTE_W-1:CPU_W];
    assign abort_mc = mc_act[FLG_MA] | mc_act[FLG_TA];

    for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
        assign mchk[c] = (mc_act[FLG_SYS] && dflt_cpu == CPU_W'(c)) ||
                         (abort_mc && mid_cpu == CPU_W'(c));
    end

    assign irq = |irq_act;

    AST_QUIET_WHEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (flags == '0) |-> (mchk == '0 && !irq)); // R6
endmodule

// File: rtl/buserr_unit.sv
module buserr_unit
    import buserr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              serr_n,
    input  logic              ma_evt,
    input  logic              ta_evt,
    input  logic [ADDR_W-1:0] txn_addr,
    input  logic [RA_W-1:0]   reg_addr,
    input  logic              wr_en,
    input  logic [WD_W-1:0]   wdata,
    output logic [ADDR_W-1:0] rdata,
    output logic [N_CPU-1:0]  mchk,
    output logic              irq
);
    logic               sys_active;
    logic [N_FLAG-1:0]  set_ev;
    logic [N_FLAG-1:0]  clr;
    logic [N_FLAG-1:0]  flag_q;
    logic [ADDR_W-1:0]  err_addr_q;
    logic [EN_W-1:0]    en_q;
    logic [ROUTE_W-1:0] route_q;
    reg_sel_t           sel;

    assign sel = reg_sel_t'(reg_addr);

    buserr_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_n  (serr_n),
        .active (sys_active)
    );

    assign set_ev = {ta_evt, ma_evt, sys_active};
    assign clr    = (wr_en && sel == REG_STATUS) ? wdata[N_FLAG-1:0] : '0;

    buserr_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_ev     (set_ev),
        .clr        (clr),
        .txn_addr   (txn_addr),
        .flag_q     (flag_q),
        .err_addr_q (err_addr_q)
    );

    buserr_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_enable (wr_en && sel == REG_ENABLE),
        .wr_route  (wr_en && sel == REG_ROUTE),
        .wdata     (wdata),
        .en_q      (en_q),
        .route_q   (route_q)
    );

    buserr_route u_route (
        .clk   (clk),
        .rst_n (rst_n),
        .flags (flag_q),
        .en    (en_q),
        .route (route_q),
        .mchk  (mchk),
        .irq   (irq)
    );

    always_comb begin
        rdata = '0;
        unique case (sel)
            REG_STATUS: rdata = ADDR_W'(flag_q);
            REG_ENABLE: rdata = ADDR_W'(en_q);
            REG_ROUTE:  rdata = ADDR_W'(route_q);
            REG_EADDR:  rdata = err_addr_q;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: tb/buserr_unit_bench.sv
module buserr_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        serr_n = 1'b1;
    logic        ma_evt = 1'b0;
    logic        ta_evt = 1'b0;
    logic [31:0] txn_addr = '0;
    logic [1:0]  reg_addr = '0;
    logic        wr_en = 1'b0;
    logic [5:0]  wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  mchk;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          kind;   // 0 rdata, 1 mchk, 2 irq
        logic [31:0] exp;
        string       req;
    } item_t;
    item_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    buserr_unit u_buserr_unit (
        .clk(clk), .rst_n(rst_n), .serr_n(serr_n), .ma_evt(ma_evt),
        .ta_evt(ta_evt), .txn_addr(txn_addr), .reg_addr(reg_addr),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .mchk(mchk), .irq(irq)
    );

    // monitor: compares queued expectations mid-cycle
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = exp_q.pop_front();
            case (it.kind)
                0:       act = rdata;
                1:       act = {30'd0, mchk};
                default: act = {31'd0, irq};
            endcase
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic push(input int kind, input logic [31:0] exp, input string req);
        item_t it;
        it.kind = kind; it.exp = exp; it.req = req;
        exp_q.push_back(it);
    endtask

    task automatic wr(input logic [1:0] a, input logic [5:0] d);
        reg_addr = a; wdata = d; wr_en = 1'b1;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
        reg_addr = a; wr_en = 1'b0;
        push(0, exp, req);
        tick();
    endtask

    task automatic outs(input logic [1:0] m, input logic i, input string req);
        push(1, {30'd0, m}, req);
        push(2, {31'd0, i}, req);
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        rd(0, 32'h0, "R1 status");
        rd(1, 32'h0, "R1 enable");
        rd(2, 32'h0, "R1 route");
        rd(3, 32'h0, "R1 eaddr");
        outs(2'b00, 1'b0, "R1 outputs");

        // R10 config readback
        wr(1, 6'h3F);
        wr(2, 6'h01);            // default cpu 1, master-id cpu 0
        rd(1, 32'h3F, "R10 enable");
        rd(2, 32'h01, "R10 route");

        // R3 master abort, R9 capture, R7 route, R8 irq
        txn_addr = 32'hA000_0010;
        ma_evt = 1'b1; tick(); ma_evt = 1'b0;
        txn_addr = 32'hB000_0020;
        rd(0, 32'h2, "R3 master abort flag");
        rd(3, 32'hA000_0010, "R9 first capture");
        outs(2'b01, 1'b1, "R7 abort to mid cpu0");

        // R3 target abort; R9 hold
        ta_evt = 1'b1; tick(); ta_evt = 1'b0;
        rd(0, 32'h6, "R3 target abort flag");
        rd(3, 32'hA000_0010, "R9 held");

        // R4 write-0 no effect, write-1 clears
        wr(0, 6'h00);
        rd(0, 32'h6, "R4 write zero");
        wr(0, 6'h02);
        rd(0, 32'h4, "R4 clear bit1");
        rd(3, 32'hA000_0010, "R9 held while pending");
        wr(2, 6'h03);            // master-id cpu 1
        outs(2'b10, 1'b1, "R7 abort to mid cpu1");
        wr(0, 6'h04);
        rd(0, 32'h0, "R4 clear bit2");
        outs(2'b00, 1'b0, "R8 all clear");

        // R9 writes to address register ignored
        wr(3, 6'h3F);
        rd(3, 32'hA000_0010, "R9 write ignored");

        // R2 system error latency, R6 default routing, R9 re-arm
        txn_addr = 32'hC000_0030;
        serr_n = 1'b0;
        tick(); tick();
        rd(0, 32'h0, "R2 not yet set");
        rd(0, 32'h1, "R2 set after sync");
        serr_n = 1'b1;
        rd(3, 32'hC000_0030, "R9 re-armed capture");
        outs(2'b10, 1'b1, "R6 sys to default cpu1");
        wr(2, 6'h02);            // default cpu 0
        outs(2'b01, 1'b1, "R6 sys to default cpu0");
        wr(1, 6'h07);            // irq enables off
        outs(2'b01, 1'b0, "R8 irq disabled");
        tick(); tick(); tick();
        wr(0, 6'h01);
        rd(0, 32'h0, "R4 clear bit0");

        // R5 set wins over same-cycle clear
        ma_evt = 1'b1; reg_addr = 0; wdata = 6'h02; wr_en = 1'b1;
        tick();
        ma_evt = 1'b0; wr_en = 1'b0;
        rd(0, 32'h2, "R5 set wins");
        wr(0, 6'h02);

        // R8 irq only, machine-check disabled
        wr(1, 6'h38);
        ta_evt = 1'b1; tick(); ta_evt = 1'b0;
        outs(2'b00, 1'b1, "R8 irq without mchk");

        tick();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule